// File: doc/BRIEF.md
# Double-Buffered Audio DMA Engine

This block moves audio samples between memory and a codec on two channels: a playback channel that reads words from memory and hands them to the codec, and a capture channel that takes words from the codec and stores them in memory. Each channel holds an active block (address and byte count) and one queued block. When the active block runs out, the queued one takes its place in the same cycle, so the sample stream has no gap. Software is then told that the queue slot is free to refill.

Software drives the engine through a small word-addressed register port: one shared control/status word plus four registers per channel. A channel is started by setting its run bit, and can be told to stop cleanly after the block in flight. Event flags share the status word with the control bits. A flag is cleared by writing a 1 to it, so writing the word back with zeros in the flag positions leaves pending events alone. One interrupt line merges all enabled flags. Memory traffic goes through a single word-wide request port with one access outstanding at a time.

Top module: `dbuf_audio_dma`

## Requirements
- R1: After reset the control/status word (index 0) reads 0x0012_0000, meaning only the two next-slot-empty bits 17 (playback) and 20 (capture) are set. `irq` and `mem_req` are low.
- R2: Register indices are: 1/2/3/4 for playback current address, current count, next address and next count; 5/6/7/8 for the same four capture registers. Writes read back unchanged. Writing a next count clears that channel's next-empty bit.
- R3: When a channel's run bit is set (bit 0 playback, bit 4 capture), its current count is zero and its next slot is full, the next pair is copied into the current pair. The next-empty bit then sets, and the channel's block flag sets (bit 16 playback, bit 19 capture).
- R4: Each `play_req` pulse on a running playback channel causes one memory read at the current address. The word read appears on `play_data` with a one-cycle `play_valid` pulse. The address then rises by 4 and the count falls by 4.
- R5: Each `cap_valid` pulse on a running capture channel causes one memory write (`mem_we`=1) of `cap_data` at the current capture address, which then advances by 4 while the count falls by 4.
- R6: When a block ends and the next slot is full, the queued block becomes current with no idle gap, and the block flag sets.
- R7: When a block ends and the next slot is empty, the channel's run bit clears. Its pipeline-empty flag sets (bit 18 playback, bit 21 capture), and so does the shared error flag (bit 22).
- R8: While a channel's pause bit is set (bit 1 playback, bit 5 capture), the block in flight completes. The run bit then clears and pipeline-empty sets, with no promotion of the queued block.
- R9: Writing 1 to a flag bit of the control/status word clears it; writing 0 there leaves it pending.
- R10: `irq` is high exactly when the global enable (bit 8) is set and at least one of the following flags is pending together with its enable: a block flag with its channel's interrupt enable (bit 2 / bit 6), a pipeline-empty flag with its enable (bit 3 / bit 7), or the error flag with the error enable (bit 9).
- R11: When both channels have a sample pending in the same cycle, the capture write is issued to memory before the playback read.
- R12: Sample strobes on a channel whose run bit is clear are ignored and produce no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write (capture), 0 = read (playback) |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data for capture |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| play_req | input | 1 | Codec asks for one playback word |
| play_valid | output | 1 | One-cycle strobe, play_data is valid |
| play_data | output | 32 | Playback word for the codec |
| cap_valid | input | 1 | Codec offers one capture word |
| cap_data | input | 32 | Capture word |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the memory holds `mem_ack` for one cycle only and only while `mem_req` is high. They also assume that the codec does not strobe a channel again before that channel's previous word has been accepted by memory, and that software does not rewrite a channel's current registers or next count while that channel is about to promote. The stimulus follows these rules: it is driven by a memory model that acknowledges every other cycle, and it leaves eight idle cycles after every sample strobe. Block lengths are all multiples of 4, and the next slot is always refilled while the current block still has words left.

// File: rtl/dbuf_audio_dma.sv
module dbuf_audio_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          play_req,
  output logic          play_valid,
  output logic [31:0]   play_data,
  input  logic          cap_valid,
  input  logic [31:0]   cap_data,
  output logic          irq
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [9:0]    ctl;
  logic [AW-1:0] ca [2];
  logic [AW-1:0] cc [2];
  logic [AW-1:0] na [2];
  logic [AW-1:0] nc [2];
  logic [1:0]    nfull, blkf, pef, pend;
  logic          err, busy, sel;
  logic [31:0]   cbuf;
  logic [1:0]    go, pau, ie, pie;

  assign go  = {ctl[4], ctl[0]};
  assign pau = {ctl[5], ctl[1]};
  assign ie  = {ctl[6], ctl[2]};
  assign pie = {ctl[7], ctl[3]};

  assign mem_req   = busy;
  assign mem_we    = sel;
  assign mem_addr  = ca[sel];
  assign mem_wdata = cbuf;
  assign irq = ctl[8] & ((|(blkf & ie)) | (|(pef & pie)) | (err & ctl[9]));

  always_comb begin
    case (reg_addr)
      4'd0: reg_rdata = {9'b0, err, pef[1], ~nfull[1], blkf[1], pef[0], ~nfull[0], blkf[0], 6'b0, ctl};
      4'd1: reg_rdata = 32'(ca[0]);
      4'd2: reg_rdata = 32'(cc[0]);
      4'd3: reg_rdata = 32'(na[0]);
      4'd4: reg_rdata = 32'(nc[0]);
      4'd5: reg_rdata = 32'(ca[1]);
      4'd6: reg_rdata = 32'(cc[1]);
      4'd7: reg_rdata = 32'(na[1]);
      4'd8: reg_rdata = 32'(nc[1]);
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; nfull <= '0; blkf <= '0; pef <= '0; pend <= '0;
      err <= 1'b0; busy <= 1'b0; sel <= 1'b0; cbuf <= '0;
      play_valid <= 1'b0; play_data <= '0;
      for (int ch = 0; ch < 2; ch++) begin
        ca[ch] <= '0; cc[ch] <= '0; na[ch] <= '0; nc[ch] <= '0;
      end
    end else begin
      play_valid <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          4'd0: begin
            ctl  <= reg_wdata[9:0];
            blkf <= blkf & ~{reg_wdata[19], reg_wdata[16]};
            pef  <= pef  & ~{reg_wdata[21], reg_wdata[18]};
            if (reg_wdata[22]) err <= 1'b0;
          end
          4'd1: ca[0] <= reg_wdata[AW-1:0];
          4'd2: cc[0] <= reg_wdata[AW-1:0];
          4'd3: na[0] <= reg_wdata[AW-1:0];
          4'd4: begin nc[0] <= reg_wdata[AW-1:0]; nfull[0] <= 1'b1; end
          4'd5: ca[1] <= reg_wdata[AW-1:0];
          4'd6: cc[1] <= reg_wdata[AW-1:0];
          4'd7: na[1] <= reg_wdata[AW-1:0];
          4'd8: begin nc[1] <= reg_wdata[AW-1:0]; nfull[1] <= 1'b1; end
          default: ;
        endcase
      end
      if (!busy) begin
        if (pend[1] && go[1] && cc[1] != '0) begin
          busy <= 1'b1; sel <= 1'b1;
        end else if (pend[0] && go[0] && cc[0] != '0) begin
          busy <= 1'b1; sel <= 1'b0;
        end
      end else if (mem_ack) begin
        busy      <= 1'b0;
        pend[sel] <= 1'b0;
        ca[sel]   <= ca[sel] + STEP;
        cc[sel]   <= cc[sel] - STEP;
        if (!sel) begin
          play_data  <= mem_rdata;
          play_valid <= 1'b1;
        end
      end
      for (int ch = 0; ch < 2; ch++) begin
        if (go[ch] && cc[ch] == '0) begin
          if (pau[ch]) begin
            ctl[4*ch] <= 1'b0; pef[ch] <= 1'b1; pend[ch] <= 1'b0;
          end else if (nfull[ch]) begin
            ca[ch] <= na[ch]; cc[ch] <= nc[ch];
            nfull[ch] <= 1'b0; blkf[ch] <= 1'b1;
          end else begin
            ctl[4*ch] <= 1'b0; pef[ch] <= 1'b1; pend[ch] <= 1'b0; err <= 1'b1;
          end
        end
      end
      if (play_req && go[0]) pend[0] <= 1'b1;
      if (cap_valid && go[1]) begin
        pend[1] <= 1'b1;
        cbuf    <= cap_data;
      end
    end
  end

  AST_PROMOTE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (go[0] && cc[0] == '0 && !pau[0] && nfull[0]) |=> blkf[0]);  // R6
  AST_UNDERRUN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (go[0] && cc[0] == '0 && !pau[0] && !nfull[0]) |=> (err && !go[0]));  // R7
  AST_PAUSE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (go[1] && cc[1] == '0 && pau[1]) |=> (!go[1] && pef[1]));  // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R5
  AST_PLAY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid |-> $past(mem_ack && mem_req && !mem_we));  // R4
  AST_REQ_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> go[mem_we]);  // R12
endmodule

// File: tb/dbuf_audio_dma_bench.sv
module dbuf_audio_dma_bench;
  localparam logic [31:0] K = 32'hA5A5_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        play_req = 1'b0;
  logic        play_valid;
  logic [31:0] play_data;
  logic        cap_valid = 1'b0;
  logic [31:0] cap_data = '0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int mem_seen = 0;

  typedef struct { logic we; logic [31:0] addr; logic [31:0] data; string tag; } mem_item_t;
  typedef struct { logic [31:0] data; string tag; } play_item_t;
  mem_item_t  q_mem[$];
  play_item_t q_play[$];

  always #2.5 clk = ~clk;

  dbuf_audio_dma u_dbuf_audio_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .play_req(play_req),
    .play_valid(play_valid), .play_data(play_data), .cap_valid(cap_valid),
    .cap_data(cap_data), .irq(irq));

  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= mem_addr ^ K;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      mem_seen++;
      if (q_mem.size() == 0) begin
        tests++; fails++;
        $display("FAIL R12 unexpected access actual=%h expected=none", mem_addr);
      end else begin
        mem_item_t e;
        e = q_mem.pop_front();
        check({e.tag, " access"}, {31'b0, mem_we}, {31'b0, e.we});
        check({e.tag, " address"}, mem_addr, e.addr);
        if (e.we) check({e.tag, " write data"}, mem_wdata, e.data);
      end
    end
    if (rst_n && play_valid) begin
      if (q_play.size() == 0) begin
        tests++; fails++;
        $display("FAIL R4 unexpected play word actual=%h expected=none", play_data);
      end else begin
        play_item_t p;
        p = q_play.pop_front();
        check({p.tag, " play data"}, play_data, p.data);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic exp_play(input logic [31:0] a, input string tag);
    mem_item_t m;
    play_item_t p;
    m.we = 1'b0; m.addr = a; m.data = '0; m.tag = tag;
    p.data = a ^ K; p.tag = tag;
    q_mem.push_back(m);
    q_play.push_back(p);
  endtask

  task automatic exp_cap(input logic [31:0] a, input logic [31:0] d, input string tag);
    mem_item_t m;
    m.we = 1'b1; m.addr = a; m.data = d; m.tag = tag;
    q_mem.push_back(m);
  endtask

  task automatic pulse_play();
    @(negedge clk); play_req = 1'b1;
    @(negedge clk); play_req = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_cap(input logic [31:0] d);
    @(negedge clk); cap_valid = 1'b1; cap_data = d;
    @(negedge clk); cap_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(4'd0, v); check("R1 status", v, 32'h0012_0000);
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 mem_req", {31'b0, mem_req}, 32'd0);
    // R2
    wr(4'd3, 32'h100); wr(4'd4, 32'd8);
    rd(4'd3, v); check("R2 next addr", v, 32'h100);
    rd(4'd4, v); check("R2 next count", v, 32'd8);
    rd(4'd0, v); check("R2 next-empty cleared", {31'b0, v[17]}, 32'd0);
    // R3
    wr(4'd0, 32'h105);
    repeat (3) @(negedge clk);
    rd(4'd1, v); check("R3 cur addr", v, 32'h100);
    rd(4'd2, v); check("R3 cur count", v, 32'd8);
    rd(4'd0, v); check("R3 flags", {29'b0, v[18:16]}, 32'd3);
    check("R10 irq on block flag", {31'b0, irq}, 32'd1);
    // R9
    wr(4'd0, 32'h105);
    rd(4'd0, v); check("R9 zero write keeps flag", {31'b0, v[16]}, 32'd1);
    wr(4'd0, 32'h0001_0105);
    rd(4'd0, v); check("R9 one write clears flag", {31'b0, v[16]}, 32'd0);
    check("R10 irq after clear", {31'b0, irq}, 32'd0);
    // R4, R6, R7
    wr(4'd3, 32'h200); wr(4'd4, 32'd4);
    exp_play(32'h100, "R4"); pulse_play();
    rd(4'd1, v); check("R4 addr step", v, 32'h104);
    rd(4'd2, v); check("R4 count step", v, 32'd4);
    exp_play(32'h104, "R4"); pulse_play();
    rd(4'd1, v); check("R6 promoted addr", v, 32'h200);
    rd(4'd2, v); check("R6 promoted count", v, 32'd4);
    rd(4'd0, v); check("R6 block flag", {31'b0, v[16]}, 32'd1);
    exp_play(32'h200, "R6"); pulse_play();
    rd(4'd0, v);
    check("R7 run cleared", {31'b0, v[0]}, 32'd0);
    check("R7 pipeline-empty", {31'b0, v[18]}, 32'd1);
    check("R7 error", {31'b0, v[22]}, 32'd1);
    // R12
    snap = mem_seen;
    pulse_play();
    check("R12 no access when stopped", 32'(mem_seen), 32'(snap));
    // R5
    wr(4'd0, 32'h007F_0100);
    wr(4'd7, 32'h300); wr(4'd8, 32'd8);
    wr(4'd0, 32'h110);
    repeat (3) @(negedge clk);
    exp_cap(32'h300, 32'hDEAD_0001, "R5"); pulse_cap(32'hDEAD_0001);
    rd(4'd5, v); check("R5 capture addr step", v, 32'h304);
    rd(4'd6, v); check("R5 capture count step", v, 32'd4);
    // R8
    wr(4'd7, 32'h400); wr(4'd8, 32'd8);
    wr(4'd0, 32'h130);
    exp_cap(32'h304, 32'hDEAD_0002, "R8"); pulse_cap(32'hDEAD_0002);
    rd(4'd0, v);
    check("R8 run cleared", {31'b0, v[4]}, 32'd0);
    check("R8 pipeline-empty", {31'b0, v[21]}, 32'd1);
    check("R8 no promotion", {31'b0, v[20]}, 32'd0);
    rd(4'd6, v); check("R8 count drained", v, 32'd0);
    // R11
    wr(4'd3, 32'h500); wr(4'd4, 32'd4);
    wr(4'd0, 32'h111);
    repeat (3) @(negedge clk);
    rd(4'd5, v); check("R11 capture promoted", v, 32'h400);
    exp_cap(32'h400, 32'hBEEF_0003, "R11 capture first");
    exp_play(32'h500, "R11 playback second");
    @(negedge clk);
    play_req = 1'b1; cap_valid = 1'b1; cap_data = 32'hBEEF_0003;
    @(negedge clk);
    play_req = 1'b0; cap_valid = 1'b0;
    repeat (12) @(negedge clk);
    // R10
    wr(4'd0, 32'h210);
    check("R10 global enable off", {31'b0, irq}, 32'd0);
    wr(4'd0, 32'h310);
    check("R10 error enabled", {31'b0, irq}, 32'd1);
    wr(4'd0, 32'h0040_0310);
    check("R10 error cleared", {31'b0, irq}, 32'd0);
    wr(4'd0, 32'h318);
    check("R10 pipeline-empty enabled", {31'b0, irq}, 32'd1);
    repeat (4) @(negedge clk);
    check("R4 all expected accesses seen", 32'(q_mem.size()), 32'd0);
    check("R4 all expected words seen", 32'(q_play.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule